// File: doc/BRIEF.md
# Counted-Loop Instruction Replay Buffer

This block sits next to the fetch unit of a small signal-processing core and removes memory fetches from tight counted loops. When the sequencer decodes a repeat instruction, it hands the block the loop body length in instructions and the number of passes. On the first pass the core fetches the body from program memory as usual. The block copies each fetched instruction, with a flag that marks it as 16-bit or 32-bit, into a small store of up to 31 entries.

On every later pass the block supplies the body from its store. The consumer takes one instruction per `adv_i` strobe. The block raises `cache_active_o` so that the fetch unit can give both memory bus sets to data traffic. The last instruction of one pass is followed at once by the first instruction of the next, so no cycle is lost between passes. After the final instruction of the final pass has been taken, the block pulses `done_o` and goes idle.

Only one loop can be held at a time. A repeat request that arrives while a loop is running is refused with an error pulse, and the running loop goes on unchanged. A zero body length, a body longer than the store, or a zero pass count is also refused with the same error pulse.

Top module: `loop_icache`

## Requirements
- R1: After reset the block is idle: `loop_busy_o`, `cache_active_o`, `instr_valid_o`, `done_o` and `err_o` are all low.
- R2: A repeat request taken while idle, with `rep_len_i` in 1..31 and `rep_cnt_i` at least 1, sets `loop_busy_o` high from the next cycle. During the first pass `cache_active_o` and `instr_valid_o` stay low.
- R3: During the first pass, each cycle with `fetch_valid_i` high stores `fetch_instr_i` and `fetch_wide_i` as the next body entry, starting at entry 0. Cycles with `fetch_valid_i` low store nothing.
- R4: During passes 2..N, `instr_valid_o` and `cache_active_o` are high and `instr_o` shows the stored entries in capture order. When `instr_wide_o` is 1 the full 32-bit word is shown; when it is 0 only bits 15:0 are kept and bits 31:16 read as zero.
- R5: In the cycle after the last entry of a non-final replay pass is taken, entry 0 is shown, with no idle cycle between passes.
- R6: `done_o` is high for exactly one cycle, the cycle after the last instruction of the final pass is taken (fetched on pass 1, or taken with `adv_i` on a replay pass). In that same cycle `loop_busy_o` is low.
- R7: With a pass count of 1 the body is fetched once, nothing is replayed, and `done_o` follows the last fetch.
- R8: A repeat request with `rep_len_i` equal to 0, or greater than 31 (the port is 6 bits wide), starts no loop and gives an `err_o` pulse in the next cycle.
- R9: A repeat request while `loop_busy_o` is high gives an `err_o` pulse in the next cycle. The running loop continues with the same contents and the same pass count.
- R10: A repeat request with `rep_cnt_i` equal to 0 starts no loop and gives an `err_o` pulse in the next cycle.
- R11: During replay, while `adv_i` is low, `instr_o` and `instr_wide_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rep_valid_i | input | 1 | Repeat instruction decoded this cycle |
| rep_len_i | input | 6 | Loop body length in instructions |
| rep_cnt_i | input | 16 | Number of passes |
| fetch_valid_i | input | 1 | A body instruction was fetched from memory this cycle |
| fetch_instr_i | input | 32 | Fetched instruction word |
| fetch_wide_i | input | 1 | Fetched instruction is 32-bit (1) or 16-bit (0) |
| adv_i | input | 1 | Consumer takes the shown replay instruction |
| instr_o | output | 32 | Replayed instruction |
| instr_wide_o | output | 1 | Replayed instruction is 32-bit |
| instr_valid_o | output | 1 | `instr_o` holds a replayed instruction |
| cache_active_o | output | 1 | The store supplies instructions; memory buses are free |
| loop_busy_o | output | 1 | A loop is being captured or replayed |
| done_o | output | 1 | One-cycle pulse at the end of the loop |
| err_o | output | 1 | One-cycle pulse when a repeat request is refused |

## Verification
Loops are run with bodies of 1, 3, 5 and 31 entries and with pass counts of 1, 2 and 4. The single-entry and full-store bodies test the wrap of the read pointer at both extremes. The count-of-one case separates done-after-capture from done-after-replay. Bodies that mix 16-bit and 32-bit words, with noise in the upper half of the 16-bit ones, show whether the width flag is kept per entry and the upper half is cleared. Runs with fetch gaps and consumer stalls separate strobe-driven stepping from free-running stepping. A repeat request sent in the middle of a loop shows that it is refused without disturbing the loop it interrupts.

// File: rtl/loop_icache_pkg.sv
package loop_icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CAPT   = 2'd1,
    ST_REPLAY = 2'd2
  } lc_state_e;

  typedef struct packed {
    logic        wide;
    logic [31:0] word;
  } lc_entry_t;
endpackage

// File: rtl/loop_icache_store.sv
module loop_icache_store
  import loop_icache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  lc_entry_t         wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output lc_entry_t         rdata_o
);
  lc_entry_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) begin
        ent_q[g].wide <= wdata_i.wide;
        // narrow words keep only the low half
        ent_q[g].word <= wdata_i.wide ? wdata_i.word : {16'h0, wdata_i.word[15:0]};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (raddr_i == AW'(k)) rdata_o = ent_q[k];
    end
  end
endmodule

// File: rtl/loop_icache_ctrl.sv
module loop_icache_ctrl
  import loop_icache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 5,
  parameter int LENW  = 6,
  parameter int CW    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rep_valid_i,
  input  logic [LENW-1:0] rep_len_i,
  input  logic [CW-1:0]   rep_cnt_i,
  input  logic            fetch_valid_i,
  input  logic            adv_i,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [AW-1:0]   raddr_o,
  output lc_state_e       state_o,
  output logic            done_o,
  output logic            err_o
);
  lc_state_e       state_q;
  logic [AW-1:0]   len_q, wr_q, rd_q;
  logic [CW-1:0]   rem_q;
  logic            done_q, err_q;
  logic            len_ok, busy, last_wr, last_rd;

  assign busy    = (state_q != ST_IDLE);
  assign len_ok  = (rep_len_i != '0) && (rep_len_i <= LENW'(DEPTH));
  assign last_wr = (wr_q == AW'(len_q - AW'(1)));
  assign last_rd = (rd_q == AW'(len_q - AW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= rep_valid_i && (busy || !len_ok || (rep_cnt_i == '0));
      unique case (state_q)
        ST_IDLE: begin
          if (rep_valid_i && len_ok && (rep_cnt_i != '0)) begin
            state_q <= ST_CAPT;
            len_q   <= AW'(rep_len_i);
            wr_q    <= '0;
            rd_q    <= '0;
            rem_q   <= rep_cnt_i - CW'(1);
          end
        end
        ST_CAPT: begin
          if (fetch_valid_i) begin
            wr_q <= wr_q + AW'(1);
            if (last_wr) begin
              rd_q <= '0;
              if (rem_q == '0) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_REPLAY;
              end
            end
          end
        end
        ST_REPLAY: begin
          if (adv_i) begin
            if (last_rd) begin
              rd_q <= '0;  // wrap with no gap cycle
              if (rem_q == CW'(1)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                rem_q <= rem_q - CW'(1);
              end
            end else begin
              rd_q <= rd_q + AW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o    = (state_q == ST_CAPT) && fetch_valid_i;
  assign waddr_o = wr_q;
  assign raddr_o = rd_q;
  assign state_o = state_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/loop_icache.sv
module loop_icache
  import loop_icache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH + 1),
  localparam int LENW = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rep_valid_i,
  input  logic [LENW-1:0] rep_len_i,
  input  logic [CW-1:0]   rep_cnt_i,
  input  logic            fetch_valid_i,
  input  logic [31:0]     fetch_instr_i,
  input  logic            fetch_wide_i,
  input  logic            adv_i,
  output logic [31:0]     instr_o,
  output logic            instr_wide_o,
  output logic            instr_valid_o,
  output logic            cache_active_o,
  output logic            loop_busy_o,
  output logic            done_o,
  output logic            err_o
);
  logic          we;
  logic [AW-1:0] waddr, raddr;
  lc_state_e     state;
  lc_entry_t     wdata, rdata;

  assign wdata = '{wide: fetch_wide_i, word: fetch_instr_i};

  loop_icache_ctrl #(.DEPTH(DEPTH), .AW(AW), .LENW(LENW), .CW(CW)) i_ctrl (
    .clk_i, .rst_ni, .rep_valid_i, .rep_len_i, .rep_cnt_i,
    .fetch_valid_i, .adv_i,
    .we_o(we), .waddr_o(waddr), .raddr_o(raddr), .state_o(state),
    .done_o, .err_o
  );

  loop_icache_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  assign instr_valid_o  = (state == ST_REPLAY);
  assign cache_active_o = (state == ST_REPLAY);
  assign loop_busy_o    = (state != ST_IDLE);
  assign instr_o        = instr_valid_o ? rdata.word : '0;
  assign instr_wide_o   = instr_valid_o && rdata.wide;
endmodule

// File: rtl/loop_icache_chk.sv
module loop_icache_chk #(
  parameter int DEPTH = 31,
  parameter int LENW  = 6,
  parameter int CW    = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rep_valid_i,
  input logic [LENW-1:0] rep_len_i,
  input logic [CW-1:0]   rep_cnt_i,
  input logic            adv_i,
  input logic [31:0]     instr_o,
  input logic            instr_wide_o,
  input logic            instr_valid_o,
  input logic            cache_active_o,
  input logic            loop_busy_o,
  input logic            done_o,
  input logic            err_o
);
  AST_NEST_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i && loop_busy_o |=> err_o); // R9
  AST_BAD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i && !loop_busy_o && ((rep_len_i == '0) || (rep_len_i > LENW'(DEPTH)))
      |=> err_o && !loop_busy_o); // R8
  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i && !loop_busy_o && (rep_cnt_i == '0) |=> err_o && !loop_busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !loop_busy_o ##1 !done_o); // R6
  AST_REPLAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !adv_i && !rep_valid_i |=> instr_valid_o && $stable(instr_o) && $stable(instr_wide_o)); // R11
  AST_ACTIVE_IN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_active_o |-> loop_busy_o && instr_valid_o); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_busy_o && !rep_valid_i |=> !loop_busy_o && !done_o); // R2
endmodule

bind loop_icache loop_icache_chk #(.DEPTH(DEPTH), .LENW(LENW), .CW(CW)) i_chk (
  .clk_i, .rst_ni, .rep_valid_i, .rep_len_i, .rep_cnt_i, .adv_i,
  .instr_o, .instr_wide_o, .instr_valid_o, .cache_active_o,
  .loop_busy_o, .done_o, .err_o
);

// File: tb/test_loop_icache.sv
`timescale 1ns/1ps
module test_loop_icache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rep_valid_i = 1'b0;
  logic [5:0]  rep_len_i = '0;
  logic [15:0] rep_cnt_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_instr_i = '0;
  logic        fetch_wide_i = 1'b0;
  logic        adv_i = 1'b0;
  logic [31:0] instr_o;
  logic        instr_wide_o, instr_valid_o, cache_active_o, loop_busy_o, done_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  always #2.5 clk_i = ~clk_i;

  loop_icache i_loop_icache (
    .clk_i, .rst_ni, .rep_valid_i, .rep_len_i, .rep_cnt_i,
    .fetch_valid_i, .fetch_instr_i, .fetch_wide_i, .adv_i,
    .instr_o, .instr_wide_o, .instr_valid_o, .cache_active_o,
    .loop_busy_o, .done_o, .err_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [31:0] word_of(int i, int seed);
    return {8'(seed), 8'(i), 8'(seed * 7 + i), 8'(i * 13 + 5)};
  endfunction

  function automatic logic wide_of(int i, int seed);
    return logic'((i + seed) % 2);
  endfunction

  function automatic logic [31:0] shown(int i, int seed);
    return wide_of(i, seed) ? word_of(i, seed) : {16'h0, word_of(i, seed)[15:0]};
  endfunction

  task automatic t_reset();
    chk("R1 busy", 32'(loop_busy_o), 0);
    chk("R1 active", 32'(cache_active_o), 0);
    chk("R1 valid", 32'(instr_valid_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 err", 32'(err_o), 0);
  endtask

  // run one loop; gaps inserts idle fetch cycles and consumer stalls
  // nest sends a repeat request in the middle of capture
  task automatic t_loop(int len, int cnt, int seed, bit gaps, bit nest);
    rep_valid_i = 1; rep_len_i = 6'(len); rep_cnt_i = 16'(cnt);
    tick();
    rep_valid_i = 0;
    chk("R2 busy after start", 32'(loop_busy_o), 1);
    chk("R2 no cache during pass 1", 32'(cache_active_o), 0);
    for (int i = 0; i < len; i++) begin
      if (gaps && i == 1) begin
        fetch_valid_i = 0; fetch_instr_i = 32'hdead_beef; tick();
      end
      fetch_valid_i = 1; fetch_instr_i = word_of(i, seed);
      fetch_wide_i = wide_of(i, seed);
      if (nest && i == 1) begin
        rep_valid_i = 1; rep_len_i = 6'd2; rep_cnt_i = 16'd1;
      end
      tick();
      if (nest && i == 1) begin
        rep_valid_i = 0;
        chk("R9 nested repeat refused", 32'(err_o), 1);
        chk("R9 loop still busy", 32'(loop_busy_o), 1);
      end
      if (i < len - 1) chk("R2 not replaying in pass 1", 32'(instr_valid_o), 0);
    end
    fetch_valid_i = 0;
    if (cnt == 1) begin
      chk("R7 done after single pass", 32'(done_o), 1);
      chk("R6 idle at done", 32'(loop_busy_o), 0);
    end
    for (int p = 1; p < cnt; p++) begin
      for (int i = 0; i < len; i++) begin
        if (gaps && i == 0 && p == 1) begin
          adv_i = 0; tick();
          chk("R11 hold word", instr_o, shown(0, seed));
          chk("R11 hold width", 32'(instr_wide_o), 32'(wide_of(0, seed)));
        end
        chk("R4 valid", 32'(instr_valid_o), 1);
        chk("R4 active", 32'(cache_active_o), 1);
        if (p > 1 && i == 0) chk("R5 wrap to entry 0", instr_o, shown(0, seed));
        else chk("R4 word", instr_o, shown(i, seed));
        chk("R4 width", 32'(instr_wide_o), 32'(wide_of(i, seed)));
        chk("R6 no early done", 32'(done_o), 0);
        adv_i = 1; tick();
      end
    end
    adv_i = 0;
    chk("R6 done pulse", 32'(done_o), 1);
    chk("R6 busy low", 32'(loop_busy_o), 0);
    chk("R6 replay off", 32'(instr_valid_o), 0);
    tick();
    chk("R6 done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_refuse(int len, int cnt, string req);
    rep_valid_i = 1; rep_len_i = 6'(len); rep_cnt_i = 16'(cnt);
    tick();
    rep_valid_i = 0;
    chk({req, " err"}, 32'(err_o), 1);
    chk({req, " no loop"}, 32'(loop_busy_o), 0);
    tick();
    chk({req, " err one cycle"}, 32'(err_o), 0);
    chk({req, " still idle"}, 32'(loop_busy_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1;
    tick();
    t_reset();
    t_loop(3, 4, 1, 0, 0);   // R4 R5 mixed widths
    t_loop(1, 4, 2, 0, 0);   // R5 single entry wrap
    t_loop(5, 1, 3, 0, 0);   // R7
    t_loop(31, 2, 4, 1, 0);  // R3 gap, R11 stall, full store
    t_loop(4, 2, 5, 0, 1);   // R9
    t_refuse(0, 3, "R8 len 0");
    t_refuse(32, 3, "R8 len 32");
    t_refuse(63, 1, "R8 len 63");
    t_refuse(3, 0, "R10 cnt 0");
    t_loop(2, 3, 6, 1, 0);   // still works after refusals
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule